// File: doc/BRIEF.md
# Three-Channel Shared-Counter PWM Generator

This block drives three pulse-width-modulated enable lines from one free-running 10-bit counter. Each channel has its own 10-bit brightness value. A channel is high from the start of each 1024-tick period until the counter passes that value, so a value n above zero gives a duty cycle of (n+1)/1024. The counter advances only on a selected tick, so the PWM period is 1024 ticks.

A command interface loads a new set of values in one clock: three brightness values, three 7-bit current scalars and a 2-bit tick-source selector. Brightness values are held as pending values and reach the comparators only when the counter wraps, so no period is cut short or stretched. The current scalars go straight to an external current regulator. A global output-enable forces all three lines low and leaves the counter running, so the phase of the period is kept.

Top module: `pwm3_top`

## Requirements
- R1: After a synchronous active-low reset the counter is 0, all active and pending brightness values are 0, the tick selector is 00, the scalars are 0 and all three outputs are low.
- R2: The counter advances by one on each selected tick, counts 0 to 1023 and then wraps to 0, and holds its value on clocks with no tick.
- R3: The tick selector picks the tick source: 00 uses `tick_int`, 01 uses `tick_ext`, 10 ticks on every clock and 11 gives no ticks at all.
- R4: When `cmd_load` is high at a clock edge, that edge captures the pending brightness values, the tick selector and the scalars. Channel i uses `cmd_bright[10*i+9:10*i]` and `cmd_scale[7*i+6:7*i]`.
- R5: A channel's pending brightness becomes its active value only at a wrap, that is a tick while the counter is 1023. Until the next wrap the output follows the old active value. The first high output after a wrap appears in the same cycle as the counter value 0.
- R6: For an active value n greater than 0 the channel is high exactly while the counter is 0 to n. That gives n+1 high ticks in every 1024, independently for each of the three channels.
- R7: An active value of 0 keeps the channel low for the whole period.
- R8: While `oe` is low all three outputs are low and the counter keeps counting. When `oe` returns high the period phase is unchanged.
- R9: `scale_out` shows the scalars captured by a load from the clock edge of that load onward, without any change to the values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_int | input | 1 | Tick enable from the internal oscillator |
| tick_ext | input | 1 | Tick enable from the external clock pin |
| oe | input | 1 | Output enable for all channels, active high |
| cmd_load | input | 1 | Load strobe for the command values |
| cmd_mode | input | 2 | Tick-source selector to load |
| cmd_bright | input | 30 | Three 10-bit brightness values, channel 0 in the low bits |
| cmd_scale | input | 21 | Three 7-bit current scalars, channel 0 in the low bits |
| pwm_out | output | 3 | PWM enable per channel |
| scale_out | output | 21 | Captured current scalars for the regulator |

## Verification
A load takes effect at the clock edge that samples it. The scalars and the tick selector are visible one clock later, and a new brightness value appears only after the next wrap. With ticks on every clock, a load made while the counter stands at 0 gives its first high output exactly 1024 clocks later. The output then stays high for n+1 clocks, and the bench checks that edge sample by sample. The duty checks wait two full periods after a load and then count high samples over a window of 1024 clocks. That count does not depend on phase. The output-enable check measures the distance between rising edges before and after the blanked stretch, and that distance must be exactly one period.

// File: rtl/pwm3_pkg.sv
// Package: shared types for the three-channel PWM generator.
// Assumes: the tick-source selector is two bits wide.
package pwm3_pkg;
    typedef enum logic [1:0] {
        TSRC_INT  = 2'b00,
        TSRC_EXT  = 2'b01,
        TSRC_CLK  = 2'b10,
        TSRC_HOLD = 2'b11
    } tick_src_t;
endpackage

// File: rtl/pwm3_tick_sel.sv
// Module: picks the counter tick enable from the selected source.
// Assumes: tick inputs are single-cycle-wide enables in the clk domain.
module pwm3_tick_sel
    import pwm3_pkg::*;
(
    input  tick_src_t src,
    input  logic      tick_int,
    input  logic      tick_ext,
    output logic      tick
);
    // Purpose: multiplex the tick source per selector value.
    always_comb begin
        unique case (src)
            TSRC_INT:  tick = tick_int;
            TSRC_EXT:  tick = tick_ext;
            TSRC_CLK:  tick = 1'b1;
            default:   tick = 1'b0;
        endcase
    end
endmodule

// File: rtl/pwm3_counter.sv
// Module: free-running period counter, 0 to 2**CW-1, advanced by tick.
// Assumes: wrap is reported in the cycle whose tick takes the count back to 0.
module pwm3_counter #(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    output logic [CW-1:0] cnt,
    output logic          wrap
);
    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    // Purpose: flag the tick that ends the period.
    assign wrap = tick && (cnt == CNT_MAX);

    // Purpose: advance the count on each tick, wrapping at the maximum.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (tick)
            cnt <= (cnt == CNT_MAX) ? '0 : cnt + 1'b1;
    end

    assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt == CNT_MAX) |=> (cnt == '0));
    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt != CNT_MAX) |=> (cnt == $past(cnt) + 1'b1));
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt));
endmodule

// File: rtl/pwm3_channel.sv
// Module: one PWM channel, with a double-buffered brightness value compared to the shared count.
// Assumes: pend is stable except on loads, and wrap comes from the shared counter.
module pwm3_channel #(
    parameter int BW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wrap,
    input  logic [BW-1:0] pend,
    input  logic [BW-1:0] cnt,
    input  logic          en,
    output logic          on
);
    logic [BW-1:0] active;

    // Purpose: copy the pending brightness to the active value at the period wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)
            active <= '0;
        else if (wrap)
            active <= pend;
    end

    // Purpose: drive high while the count is within 0..active, never for zero.
    always_comb begin
        on = en && (active != '0) && (cnt <= active);
    end

    assert_defer_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(active));
    assert_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (active == $past(pend)));
endmodule

// File: rtl/pwm3_top.sv
// Module: three-channel PWM generator with a shared counter and a command register bank.
// Assumes: tick inputs are synchronous to clk, and cmd_* are valid whenever cmd_load is high.
module pwm3_top
    import pwm3_pkg::*;
#(
    parameter int NCH = 3,
    parameter int BW  = 10,
    parameter int SW  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_int,
    input  logic              tick_ext,
    input  logic              oe,
    input  logic              cmd_load,
    input  logic [1:0]        cmd_mode,
    input  logic [NCH*BW-1:0] cmd_bright,
    input  logic [NCH*SW-1:0] cmd_scale,
    output logic [NCH-1:0]    pwm_out,
    output logic [NCH*SW-1:0] scale_out
);
    localparam int BRW = NCH * BW;
    localparam int SCW = NCH * SW;

    tick_src_t       mode_q;
    logic [BRW-1:0]  bright_q;
    logic [SCW-1:0]  scale_q;
    logic            tick;
    logic            wrap;
    logic [BW-1:0]   cnt;

    // Purpose: command register bank, captured on a load strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= TSRC_INT;
            bright_q <= '0;
            scale_q  <= '0;
        end else if (cmd_load) begin
            mode_q   <= tick_src_t'(cmd_mode);
            bright_q <= cmd_bright;
            scale_q  <= cmd_scale;
        end
    end

    assign scale_out = scale_q;

    pwm3_tick_sel u_tsel (
        .src      (mode_q),
        .tick_int (tick_int),
        .tick_ext (tick_ext),
        .tick     (tick)
    );

    pwm3_counter #(.CW(BW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .cnt   (cnt),
        .wrap  (wrap)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        pwm3_channel #(.BW(BW)) u_ch (
            .clk   (clk),
            .rst_n (rst_n),
            .wrap  (wrap),
            .pend  (bright_q[g*BW +: BW]),
            .cnt   (cnt),
            .en    (oe),
            .on    (pwm_out[g])
        );
    end

    assert_scale_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_load |=> (scale_out == $past(cmd_scale)));
    assert_hold_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == TSRC_HOLD) |-> !tick);
    assert_blank_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> (pwm_out == '0));
    assert_reset_R1: assert property (@(posedge clk)
        $past(!rst_n) |-> (pwm_out == '0 && scale_out == '0));
endmodule

// File: tb/sim_pwm3_top.sv
module sim_pwm3_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_int = 1'b0;
    logic        tick_ext = 1'b0;
    logic        oe = 1'b1;
    logic        cmd_load = 1'b0;
    logic [1:0]  cmd_mode = 2'b00;
    logic [29:0] cmd_bright = '0;
    logic [20:0] cmd_scale = '0;
    logic [2:0]  pwm_out;
    logic [20:0] scale_out;

    int checks = 0;
    int errors = 0;
    logic [9:0] b0 = '0, b1 = '0, b2 = '0;

    always #2 clk = ~clk;

    pwm3_top u0 (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_load(input logic [1:0] m, input logic [9:0] x0, input logic [9:0] x1,
                           input logic [9:0] x2, input logic [20:0] sc);
        @(negedge clk);
        b0 = x0; b1 = x1; b2 = x2;
        cmd_mode = m; cmd_bright = {x2, x1, x0}; cmd_scale = sc; cmd_load = 1'b1;
        @(negedge clk);
        cmd_load = 1'b0;
    endtask

    task automatic count_high(input int n, output int h0, output int h1, output int h2);
        h0 = 0; h1 = 0; h2 = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            h0 += int'(pwm_out[0]); h1 += int'(pwm_out[1]); h2 += int'(pwm_out[2]);
        end
    endtask

    task automatic count_changes(input int n, output int c);
        logic [2:0] prev;
        c = 0;
        prev = pwm_out;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (pwm_out != prev) c++;
            prev = pwm_out;
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(pwm_out == 3'b000, "R1 outputs low after reset", int'(pwm_out), 0);
        chk(scale_out == '0, "R1 scalars zero after reset", int'(scale_out), 0);
    endtask

    // Counter frozen at 0 after reset (no internal tick), so the first wrap time is exact.
    task automatic t_deferred;
        int first_hi;
        int run;
        do_load(2'b11, 10'd5, 10'd0, 10'd0, 21'd0);
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
        end
        chk(pwm_out == 3'b000, "R5 pending value unused before wrap", int'(pwm_out), 0);
        do_load(2'b10, 10'd5, 10'd0, 10'd0, 21'd0);
        first_hi = -1;
        run = 0;
        for (int k = 1; k <= 1031; k++) begin
            @(negedge clk);
            if (pwm_out[0]) begin
                if (first_hi < 0) first_hi = k;
                run++;
            end
        end
        chk(first_hi == 1024, "R5 R2 first high sample after wrap", first_hi, 1024);
        chk(run == 6, "R6 high run length for value 5", run, 6);
    endtask

    task automatic t_duty(input logic [9:0] x0, input logic [9:0] x1, input logic [9:0] x2);
        int h0, h1, h2;
        int e0, e1, e2;
        do_load(2'b10, x0, x1, x2, 21'd0);
        count_high(2048, h0, h1, h2);
        count_high(1024, h0, h1, h2);
        e0 = (x0 == 0) ? 0 : int'(x0) + 1;
        e1 = (x1 == 0) ? 0 : int'(x1) + 1;
        e2 = (x2 == 0) ? 0 : int'(x2) + 1;
        chk(h0 == e0, (x0 == 0) ? "R7 zero value stays off ch0" : "R6 duty ch0", h0, e0);
        chk(h1 == e1, (x1 == 0) ? "R7 zero value stays off ch1" : "R6 duty ch1", h1, e1);
        chk(h2 == e2, (x2 == 0) ? "R7 zero value stays off ch2" : "R6 duty ch2", h2, e2);
    endtask

    task automatic t_oe;
        int t;
        int hi;
        logic prev;
        do_load(2'b10, 10'd5, 10'd5, 10'd5, 21'd0);
        for (int k = 0; k < 2048; k++) begin
            @(negedge clk);
        end
        prev = pwm_out[0];
        t = 0;
        while (!(pwm_out[0] && !prev) && t < 3000) begin
            prev = pwm_out[0];
            @(negedge clk);
            t++;
        end
        t = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk); t++;
        end
        oe = 1'b0;
        hi = 0;
        for (int k = 0; k < 500; k++) begin
            @(negedge clk); t++;
            hi += int'(pwm_out != 3'b000);
        end
        chk(hi == 0, "R8 outputs low while oe low", hi, 0);
        oe = 1'b1;
        prev = pwm_out[0];
        while (!(pwm_out[0] && !prev) && t < 3000) begin
            prev = pwm_out[0];
            @(negedge clk);
            t++;
        end
        chk(t == 1024, "R8 counter kept running under oe low", t, 1024);
    endtask

    task automatic t_mode;
        int c, h0, h1, h2;
        do_load(2'b10, 10'd511, 10'd511, 10'd511, 21'd0);
        count_high(2048, h0, h1, h2);
        tick_int = 1'b1; tick_ext = 1'b1;
        do_load(2'b11, 10'd511, 10'd511, 10'd511, 21'd0);
        count_changes(2000, c);
        chk(c == 0, "R3 selector 11 gives no ticks", c, 0);
        tick_ext = 1'b0;
        do_load(2'b00, 10'd511, 10'd511, 10'd511, 21'd0);
        count_high(1024, h0, h1, h2);
        chk(h0 == 512, "R3 selector 00 follows tick_int", h0, 512);
        do_load(2'b01, 10'd511, 10'd511, 10'd511, 21'd0);
        count_changes(2000, c);
        chk(c == 0, "R3 selector 01 ignores tick_int", c, 0);
        tick_ext = 1'b1; tick_int = 1'b0;
        count_high(1024, h0, h1, h2);
        chk(h1 == 512, "R3 selector 01 follows tick_ext", h1, 512);
        do_load(2'b00, 10'd511, 10'd511, 10'd511, 21'd0);
        count_changes(2000, c);
        chk(c == 0, "R3 selector 00 ignores tick_ext", c, 0);
        tick_ext = 1'b0;
    endtask

    task automatic t_scale;
        do_load(2'b11, b0, b1, b2, {7'h55, 7'h2A, 7'h7F});
        chk(scale_out == {7'h55, 7'h2A, 7'h7F}, "R9 R4 scalars after load",
            int'(scale_out), int'({7'h55, 7'h2A, 7'h7F}));
        @(negedge clk);
        cmd_scale = 21'h1ABCDE;
        @(negedge clk);
        chk(scale_out == {7'h55, 7'h2A, 7'h7F}, "R4 scalars held without load",
            int'(scale_out), int'({7'h55, 7'h2A, 7'h7F}));
        do_load(2'b11, b0, b1, b2, 21'h0F0F0F);
        chk(scale_out == 21'h0F0F0F, "R9 second scalar pattern", int'(scale_out), int'(21'h0F0F0F));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_deferred();
        t_duty(10'd0, 10'd1, 10'd1023);
        t_duty(10'd511, 10'd100, 10'd1022);
        t_oe();
        t_mode();
        t_scale();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule